// File: doc/BRIEF.md
# Multiplexed-Bus Register Interface with Interrupts

This block is the slave side of an 8-bit microcontroller port. The port shares one 8-bit bus between address and data. The controller first places a register address on the bus and pulses the latch-enable strobe. It then runs a read or a write qualified by an active-low chip select and active-low read or write strobes. All strobes and the bus arrive without a clock relationship to the block. They pass through two-flop synchronisers before the internal clock domain acts on them.

Behind the port sits a small register bank: a parameterised number of read/write control bytes, which also appear as outputs to the rest of the chip, an interrupt pending register and an interrupt mask register. Three event inputs set the sticky pending bits: transmit frame end, receive frame end and frame error. The interrupt request is the OR of every pending bit whose mask bit is set. Software acknowledges an event by writing a 1 to its pending bit.

The bus pad is modelled as separate in, out and output-enable signals.

Top module: `mux_bus_regif`

## Requirements
- R1: After reset every control byte, the pending bits and the mask bits are 0, `irqOut` is low and `busOe` is low.
- R2: The register address is taken from the bus when the latch-enable strobe falls. Later reads and writes use that address until the next falling latch-enable edge. The bus must hold the address for at least 3 clocks after the fall.
- R3: A write is committed when `wrN` rises while `csN` is low. The committed data is the bus value sampled while `wrN` was low. Control byte i sits at address i, for i from 0 to NUM_CTRL-1, and appears on `ctrlRegs[8*i+7:8*i]`. A write strobe while `csN` is high has no effect.
- R4: `busOe` is high exactly while both `csN` and `rdN` are low. While it is high, `busOut` carries the contents of the latched address.
- R5: A one-clock pulse on `txEndEvt`, `rxEndEvt` or `frameErrEvt` sets pending bit 0, 1 or 2 respectively. The pending register is at address 0x08. A pending bit stays set until software clears it.
- R6: The mask register is at address 0x09, with bits [2:0] in the same order as the pending bits. `irqOut` is high exactly when some pending bit and its mask bit are both 1. It follows an event or a mask change within one clock of the internal update.
- R7: Writing to address 0x08 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R8: If an event for a bit arrives in the same clock as a write that clears that bit, the bit stays set.
- R9: A read of any address other than the control bytes, 0x08 and 0x09 returns 0x00. A write to such an address changes no register. Bits [7:3] of the pending and mask registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aleIn | input | 1 | Address latch enable; the address is taken on its falling edge |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busIn | input | 8 | Bus value seen at the pad |
| busOut | output | 8 | Read data to the pad |
| busOe | output | 1 | Pad output enable |
| txEndEvt | input | 1 | Transmit frame end pulse |
| rxEndEvt | input | 1 | Receive frame end pulse |
| frameErrEvt | input | 1 | Frame error pulse |
| ctrlRegs | output | 8*NUM_CTRL | Control byte contents |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
A wrong latched address or a mistimed commit shows up in two places. A later read returns the wrong byte, and `ctrlRegs` carries the wrong value as soon as the write completes, a few clocks after `wrN` rises. A corrupted pending or mask bit shows on `irqOut` one clock after the internal update, and in the next read of 0x08 or 0x09. The clear-versus-event race is aimed at the exact commit clock, so a design that lets the clear win loses the bit, and the loss is visible on `irqOut` and in the next read.

// File: rtl/regif_pkg.sv
package regif_pkg;
  typedef struct packed {
    logic addrLoad;
    logic dataLoad;
    logic wrCommit;
  } strobeT;
endpackage

// File: rtl/regif_busctrl.sv
module regif_busctrl
  import regif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleIn,
  input  logic              csN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busSync,
  output strobeT            strb
);
  logic [1:0] aleS, csS, wrS;
  logic alePrev, wrPrev;
  logic [DATA_W-1:0] busS1, busS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleS    <= 2'b00;
      csS     <= 2'b11;
      wrS     <= 2'b11;
      alePrev <= 1'b0;
      wrPrev  <= 1'b1;
      busS1   <= '0;
      busS2   <= '0;
    end else begin
      aleS    <= {aleS[0], aleIn};
      csS     <= {csS[0], csN};
      wrS     <= {wrS[0], wrN};
      alePrev <= aleS[1];
      wrPrev  <= wrS[1];
      busS1   <= busIn;
      busS2   <= busS1;
    end
  end

  assign busSync       = busS2;
  assign strb.addrLoad = alePrev & ~aleS[1];
  assign strb.dataLoad = ~wrS[1] & ~csS[1];
  assign strb.wrCommit = ~wrPrev & wrS[1] & ~csS[1];

  // R3
  single_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |=> !strb.wrCommit);
  // R3
  commit_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |-> $past(strb.dataLoad));
endmodule

// File: rtl/regif_datapath.sv
module regif_datapath
  import regif_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          NUM_CTRL  = 2,
  parameter int          NUM_SRC   = 3,
  parameter logic [7:0]  PEND_ADDR = 8'h08,
  parameter logic [7:0]  MASK_ADDR = 8'h09
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strb,
  input  logic [DATA_W-1:0]          busSync,
  input  logic [NUM_SRC-1:0]         evtVec,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_CTRL*DATA_W-1:0] ctrlRegs,
  output logic                       irqOut
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [DATA_W-1:0]  addrQ, wrDataQ;
  logic [NUM_SRC-1:0] pendQ, maskQ;
  logic [DATA_W-1:0]  ctrlQ [NUM_CTRL];
  logic pendHit, maskHit;

  assign pendHit = strb.wrCommit && (addrQ == PEND_ADDR);
  assign maskHit = strb.wrCommit && (addrQ == MASK_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      pendQ   <= '0;
      maskQ   <= '0;
    end else begin
      if (strb.addrLoad) addrQ <= busSync;
      if (strb.dataLoad) wrDataQ <= busSync;
      if (maskHit) maskQ <= wrDataQ[NUM_SRC-1:0];
      pendQ <= (pendHit ? (pendQ & ~wrDataQ[NUM_SRC-1:0]) : pendQ) | evtVec;
    end
  end

  for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_ctrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctrlQ[gi] <= '0;
      else if (strb.wrCommit && (addrQ == gi[DATA_W-1:0])) ctrlQ[gi] <= wrDataQ;
    end
    assign ctrlRegs[gi*DATA_W +: DATA_W] = ctrlQ[gi];
  end

  always_comb begin
    rdData = '0;
    if (addrQ == PEND_ADDR) rdData = {{PAD_W{1'b0}}, pendQ};
    else if (addrQ == MASK_ADDR) rdData = {{PAD_W{1'b0}}, maskQ};
    for (int i = 0; i < NUM_CTRL; i++)
      if (addrQ == i[DATA_W-1:0]) rdData = ctrlQ[i];
  end

  assign irqOut = |(pendQ & maskQ);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.addrLoad |=> $stable(addrQ));
  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendHit |=> ((pendQ & $past(pendQ)) == $past(pendQ)));
  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((pendQ & $past(evtVec)) == $past(evtVec)));
  // R6
  irq_on_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evtVec & maskQ) != '0) && !maskHit |=> irqOut);
  // R9
  mask_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskHit |=> $stable(maskQ));
endmodule

// File: rtl/mux_bus_regif.sv
module mux_bus_regif
  import regif_pkg::*;
#(
  parameter int         NUM_CTRL  = 2,
  parameter logic [7:0] PEND_ADDR = 8'h08,
  parameter logic [7:0] MASK_ADDR = 8'h09
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  aleIn,
  input  logic                  csN,
  input  logic                  rdN,
  input  logic                  wrN,
  input  logic [7:0]            busIn,
  output logic [7:0]            busOut,
  output logic                  busOe,
  input  logic                  txEndEvt,
  input  logic                  rxEndEvt,
  input  logic                  frameErrEvt,
  output logic [NUM_CTRL*8-1:0] ctrlRegs,
  output logic                  irqOut
);
  localparam int DATA_W  = 8;
  localparam int NUM_SRC = 3;

  strobeT            strb;
  logic [DATA_W-1:0] busSync, rdData;

  regif_busctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .csN(csN), .wrN(wrN),
    .busIn(busIn), .busSync(busSync), .strb(strb)
  );

  regif_datapath #(
    .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL), .NUM_SRC(NUM_SRC),
    .PEND_ADDR(PEND_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busSync(busSync),
    .evtVec({frameErrEvt, rxEndEvt, txEndEvt}),
    .rdData(rdData), .ctrlRegs(ctrlRegs), .irqOut(irqOut)
  );

  assign busOe  = ~csN & ~rdN;
  assign busOut = busOe ? rdData : '0;
endmodule

// File: tb/mux_bus_regif_tb.sv
module mux_bus_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTRL = 2;

  logic clk = 0, rstN = 0;
  logic aleIn = 0, csN = 1, rdN = 1, wrN = 1;
  logic [7:0] busIn = 0, busOut;
  logic busOe, irqOut;
  logic txEndEvt = 0, rxEndEvt = 0, frameErrEvt = 0;
  logic [NUM_CTRL*8-1:0] ctrlRegs;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] ctrlM [NUM_CTRL];
  logic [2:0] pendM = 0, maskM = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_regif #(.NUM_CTRL(NUM_CTRL)) u_dut (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .txEndEvt(txEndEvt),
    .rxEndEvt(rxEndEvt), .frameErrEvt(frameErrEvt), .ctrlRegs(ctrlRegs),
    .irqOut(irqOut)
  );

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (a < NUM_CTRL) return ctrlM[a];
    if (a == 8'h08) return {5'b0, pendM};
    if (a == 8'h09) return {5'b0, maskM};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAddr(input logic [7:0] a);
    @(negedge clk); aleIn = 1; busIn = a;
    ticks(2); aleIn = 0;
    ticks(4);
  endtask

  task automatic busWrite(input logic [7:0] d, input bit useCs);
    @(negedge clk); busIn = d; csN = !useCs; wrN = 0;
    ticks(4); wrN = 1;
    ticks(4); csN = 1;
    ticks(2);
  endtask

  task automatic busRead(input string req, input logic [7:0] a);
    @(negedge clk); csN = 0; rdN = 0;
    @(negedge clk);
    check(req, busOe, 1'b1);
    check(req, busOut, expRead(a));
    csN = 1; rdN = 1;
    @(negedge clk);
    check("R4 oe off", busOe, 1'b0);
  endtask

  task automatic pulse(input logic [2:0] e);
    @(negedge clk); {frameErrEvt, rxEndEvt, txEndEvt} = e;
    @(negedge clk); {frameErrEvt, rxEndEvt, txEndEvt} = 3'b0;
    pendM |= e;
    @(negedge clk);
  endtask

  task automatic writeModel(input logic [7:0] a, input logic [7:0] d);
    if (a < NUM_CTRL) ctrlM[a] = d;
    else if (a == 8'h08) pendM &= ~d[2:0];
    else if (a == 8'h09) maskM = d[2:0];
  endtask

  task automatic checkState(input string req);
    check(req, irqOut, |(pendM & maskM));
    for (int i = 0; i < NUM_CTRL; i++) check(req, ctrlRegs[i*8 +: 8], ctrlM[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, d;
    logic [2:0] e;
    for (int i = 0; i < NUM_CTRL; i++) ctrlM[i] = 0;
    void'($urandom(32'd4711));
    ticks(3); rstN = 1; ticks(2);
    // R1 reset state
    check("R1 irq", irqOut, 1'b0);
    check("R1 oe", busOe, 1'b0);
    check("R1 ctrl", ctrlRegs, '0);
    setAddr(8'h08); busRead("R1 pend", 8'h08);
    // R2 R3 directed write/read
    setAddr(8'h00); busWrite(8'hA5, 1); writeModel(8'h00, 8'hA5);
    setAddr(8'h01); busWrite(8'h3C, 1); writeModel(8'h01, 8'h3C);
    checkState("R3 write");
    setAddr(8'h00); busRead("R2 addr 0", 8'h00);
    setAddr(8'h01); busRead("R2 addr 1", 8'h01);
    // R3 write without chip select ignored
    setAddr(8'h00); busWrite(8'hFF, 0);
    checkState("R3 no cs");
    busRead("R3 no cs read", 8'h00);
    // R5 R6 events with mask closed, then open
    pulse(3'b010);
    checkState("R6 masked");
    setAddr(8'h08); busRead("R5 pend", 8'h08);
    setAddr(8'h09); busWrite(8'hFF, 1); writeModel(8'h09, 8'hFF);
    checkState("R6 unmasked");
    busRead("R9 mask upper", 8'h09);
    // R7 partial clear
    pulse(3'b101);
    setAddr(8'h08); busWrite(8'h01, 1); writeModel(8'h08, 8'h01);
    busRead("R7 partial clear", 8'h08);
    checkState("R7 irq");
    // R8 clear racing an event on bit 1
    @(negedge clk); busIn = 8'h06; csN = 0; wrN = 0;
    ticks(4); wrN = 1;
    @(posedge clk); @(posedge clk); @(negedge clk); rxEndEvt = 1;
    @(negedge clk); rxEndEvt = 0;
    ticks(3); csN = 1; ticks(2);
    pendM = (pendM & ~3'b110) | 3'b010;
    busRead("R8 race", 8'h08);
    checkState("R8 irq");
    // R9 unmapped
    setAddr(8'h05); busWrite(8'h77, 1);
    busRead("R9 unmapped", 8'h05);
    checkState("R9 no effect");
    setAddr(8'hFE); busRead("R9 high addr", 8'hFE);
    // random mix
    for (int k = 0; k < 60; k++) begin
      a = 8'($urandom_range(0, 11));
      d = 8'($urandom);
      e = 3'($urandom);
      case ($urandom_range(0, 2))
        0: begin setAddr(a); busWrite(d, 1); writeModel(a, d); checkState("R3 rand"); end
        1: begin setAddr(a); busRead("R4 rand", a); end
        default: begin pulse(e); checkState("R5 rand"); end
      endcase
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule